// File: doc/BRIEF.md
# Hashed Page Table Walker

This block searches a hashed page table held in memory for the entry that maps one effective address. It takes a virtual segment identifier, the effective address, a read/write flag, and the table's base and mask values. From these it forms a hash of the segment identifier and the page index, which selects a group of eight two-word entries. It reads those entries one after another over a simple synchronous memory port. If none of them matches, it takes the bitwise complement of the hash, which selects a second group, and searches that group.

On a match, the walker sets the referenced flag in the entry's second word. On a write access it also sets the changed flag. It writes that word back only if its value actually changes. It then reports the physical address and the two-bit protection field with a one-cycle done pulse. If both groups miss, it raises the same pulse with the hit flag low. The walker makes no protection decision; the caller does that.

Top module: `hpw_walker`

## Requirements
- R1: While reset is held, and whenever the walker is idle, busy, done, mem_rd and mem_wr are all low.
- R2: The first read of a walk goes to tbl_base | (((vsid ^ ea[27:12]) << 6) & tbl_mask). The following reads step through the eight entries of the group in rising order, 8 bytes apart. Every read address is 8-byte aligned.
- R3: An entry matches only if all of these hold in its first word: bit 31 (valid) is 1, bit 6 (group select) equals the current phase (0 in the first group, 1 in the second), bits 30:7 equal vsid, and bits 5:0 equal ea[27:22]. Every other entry is passed over.
- R4: The second group, at the address formed from the complement of the 24-bit hash, is read only after all eight entries of the first group miss. Its first read is the ninth read of the walk.
- R5: When several entries of a group match, the entry with the lowest position is used, and the walk stops reading there.
- R6: On a hit, bit 8 (referenced) of the second word is set. If is_write is 1, bit 7 (changed) is also set. The result is written in a single write to the entry address + 4, and done follows in the next cycle.
- R7: When the updated second word equals the stored one, no write is made.
- R8: On a hit, done comes with hit = 1, pa = {word1[31:12], ea[11:0]} and pp = word1[1:0].
- R9: When neither group holds a match, done comes with hit = 0 after exactly 16 reads, and no write is made.
- R10: done is high for exactly one cycle per walk. busy is low in the cycle after done. mem_rd and mem_wr are never high together.
- R11: A start pulse while busy is high is ignored, and the walk in progress completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| is_write | input | 1 | Access is a store; sets the changed flag on a hit |
| vsid | input | 24 | Virtual segment identifier |
| ea | input | 32 | Effective address |
| tbl_base | input | 32 | Table base address, zero under tbl_mask |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Valid with done: entry found |
| pa | output | 32 | Valid with done and hit: physical address |
| pp | output | 2 | Valid with done and hit: protection field |
| mem_rd | output | 1 | Read one entry at mem_addr; data arrives next cycle |
| mem_wr | output | 1 | Write mem_wdata to the word at mem_addr |
| mem_addr | output | 32 | Byte address of the memory access |
| mem_wdata | output | 32 | Updated second word of the entry |
| mem_rdata | input | 64 | Entry read back: first word in bits 63:32, second word in bits 31:0 |

## Verification
The walker is driven with several table layouts:
- A match in the first group, which pins down the address hash and the read count.
- A first group full of near-misses, each wrong in only one field (valid, phase bit, tag or segment), which shows that each field of the compare matters, while the real entry sits in the second group behind an entry with the wrong phase bit.
- Two matching entries in one group, which separates first-match order from last-match order.
- An empty table, which exposes the miss path and its read count of 16.

Read and write accesses are run against entries whose flags are clear, partly set and fully set. This separates a write that always happens from a write that happens only when the word changes. A narrower mask checks that the hash is masked, and a start pulse in the middle of a walk checks that it is ignored.

// File: rtl/hpw_pkg.sv
`timescale 1ns/1ps
package hpw_pkg;
   localparam int WORD_W  = 32;
   localparam int V_BIT   = WORD_W - 1;
   localparam int REF_BIT = 8;
   localparam int CHG_BIT = 7;
   localparam int PP_W    = 2;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ISSUE,
      S_CHECK,
      S_WBACK,
      S_DONE
   } walk_st_e;
endpackage

// File: rtl/hpw_hash.sv
`timescale 1ns/1ps
module hpw_hash #(
   parameter int VSID_W  = 24,
   parameter int EA_W    = 32,
   parameter int PA_W    = 32,
   parameter int PAGE_W  = 12,
   parameter int SEG_W   = 28,
   parameter int API_W   = SEG_W - PAGE_W - 10,
   parameter int GROUP_N = 8,
   parameter int ENTRY_B = 8
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [EA_W-1:0]   ea,
   input  logic              second,
   input  logic [PA_W-1:0]   tbl_base,
   input  logic [PA_W-1:0]   tbl_mask,
   output logic [PA_W-1:0]   grp_addr,
   output logic [API_W-1:0]  api
);
   localparam int PIDX_W = SEG_W - PAGE_W;
   localparam int HASH_W = (VSID_W > PIDX_W) ? VSID_W : PIDX_W;
   localparam int GRP_SH = $clog2(GROUP_N * ENTRY_B);

   logic [PIDX_W-1:0] pidx;
   logic [HASH_W-1:0] hash;
   logic [HASH_W-1:0] hsel;
   logic [PA_W-1:0]   hwide;

   assign pidx = ea[SEG_W-1:PAGE_W];
   assign api  = pidx[PIDX_W-1 -: API_W];

   generate
      if (VSID_W > PIDX_W) begin : g_vsid_wider
         assign hash = vsid ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
      end else if (VSID_W == PIDX_W) begin : g_same_width
         assign hash = vsid ^ pidx;
      end else begin : g_pidx_wider
         assign hash = {{(HASH_W-VSID_W){1'b0}}, vsid} ^ pidx;
      end
   endgenerate

   assign hsel = second ? ~hash : hash;

   generate
      if (HASH_W >= PA_W) begin : g_trunc
         assign hwide = hsel[PA_W-1:0];
      end else begin : g_extend
         assign hwide = {{(PA_W-HASH_W){1'b0}}, hsel};
      end
   endgenerate

   assign grp_addr = tbl_base | ((hwide << GRP_SH) & tbl_mask);
endmodule

// File: rtl/hpw_cmp.sv
`timescale 1ns/1ps
module hpw_cmp
   import hpw_pkg::*;
#(
   parameter int VSID_W = 24,
   parameter int API_W  = 6
) (
   input  logic [WORD_W-1:0] w0,
   input  logic [WORD_W-1:0] w1,
   input  logic              second,
   input  logic [VSID_W-1:0] vsid,
   input  logic [API_W-1:0]  api,
   input  logic              is_write,
   output logic              match,
   output logic [WORD_W-1:0] upd_w1,
   output logic              upd_need
);
   localparam int H_POS = API_W;
   localparam int VS_LO = API_W + 1;

   assign match = w0[V_BIT]
                  && (w0[H_POS] == second)
                  && (w0[VS_LO +: VSID_W] == vsid)
                  && (w0[API_W-1:0] == api);

   always_comb begin
      upd_w1          = w1;
      upd_w1[REF_BIT] = 1'b1;
      if (is_write) upd_w1[CHG_BIT] = 1'b1;
   end

   assign upd_need = (upd_w1 != w1);
endmodule

// File: rtl/hpw_walker.sv
`timescale 1ns/1ps
module hpw_walker
   import hpw_pkg::*;
#(
   parameter int VSID_W  = 24,
   parameter int EA_W    = 32,
   parameter int PA_W    = 32,
   parameter int PAGE_W  = 12,
   parameter int SEG_W   = 28,
   parameter int GROUP_N = 8,
   parameter int ENTRY_B = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                is_write,
   input  logic [VSID_W-1:0]   vsid,
   input  logic [EA_W-1:0]     ea,
   input  logic [PA_W-1:0]     tbl_base,
   input  logic [PA_W-1:0]     tbl_mask,
   output logic                busy,
   output logic                done,
   output logic                hit,
   output logic [PA_W-1:0]     pa,
   output logic [PP_W-1:0]     pp,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic [PA_W-1:0]     mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic [2*WORD_W-1:0] mem_rdata
);
   localparam int API_W  = SEG_W - PAGE_W - 10;
   localparam int IDX_W  = $clog2(GROUP_N);
   localparam int ENT_SH = $clog2(ENTRY_B);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_N - 1);
   localparam logic [PA_W-1:0]  HALF_OFF  = PA_W'(ENTRY_B / 2);

   generate
      if (API_W < 1) begin : g_err_api
         $error("segment too small for a tag field");
      end
      if (VSID_W + API_W + 2 != WORD_W) begin : g_err_layout
         $error("tag fields must fill the first entry word");
      end
      if ((GROUP_N < 2) || ((GROUP_N & (GROUP_N - 1)) != 0)) begin : g_err_grp
         $error("GROUP_N must be a power of two of at least 2");
      end
      if (ENTRY_B != 2 * (WORD_W / 8)) begin : g_err_ent
         $error("an entry is two words");
      end
      if ((PA_W > WORD_W) || (PAGE_W <= REF_BIT) || (EA_W < SEG_W)) begin : g_err_addr
         $error("address widths do not fit the entry layout");
      end
   endgenerate

   walk_st_e          st;
   logic              second;
   logic [IDX_W-1:0]  slot;
   logic [VSID_W-1:0] vsid_q;
   logic [EA_W-1:0]   ea_q;
   logic              wr_q;
   logic [PA_W-1:0]   base_q;
   logic [PA_W-1:0]   mask_q;
   logic [WORD_W-1:0] wdata_q;
   logic              hit_q;
   logic [PA_W-1:0]   pa_q;
   logic [PP_W-1:0]   pp_q;

   logic [PA_W-1:0]   grp_addr;
   logic [API_W-1:0]  api;
   logic [PA_W-1:0]   ent_addr;
   logic [WORD_W-1:0] w0;
   logic [WORD_W-1:0] w1;
   logic              match;
   logic [WORD_W-1:0] upd_w1;
   logic              upd_need;

   hpw_hash #(
      .VSID_W (VSID_W), .EA_W (EA_W), .PA_W (PA_W), .PAGE_W (PAGE_W),
      .SEG_W (SEG_W), .API_W (API_W), .GROUP_N (GROUP_N), .ENTRY_B (ENTRY_B)
   ) u_hash (
      .vsid     (vsid_q),
      .ea       (ea_q),
      .second   (second),
      .tbl_base (base_q),
      .tbl_mask (mask_q),
      .grp_addr (grp_addr),
      .api      (api)
   );

   assign w0 = mem_rdata[2*WORD_W-1:WORD_W];
   assign w1 = mem_rdata[WORD_W-1:0];

   hpw_cmp #(.VSID_W (VSID_W), .API_W (API_W)) u_cmp (
      .w0       (w0),
      .w1       (w1),
      .second   (second),
      .vsid     (vsid_q),
      .api      (api),
      .is_write (wr_q),
      .match    (match),
      .upd_w1   (upd_w1),
      .upd_need (upd_need)
   );

   assign ent_addr  = grp_addr | (PA_W'(slot) << ENT_SH);
   assign mem_rd    = (st == S_ISSUE);
   assign mem_wr    = (st == S_WBACK);
   assign mem_addr  = (st == S_WBACK) ? (ent_addr | HALF_OFF) : ent_addr;
   assign mem_wdata = wdata_q;
   assign busy      = (st != S_IDLE);
   assign done      = (st == S_DONE);
   assign hit       = hit_q;
   assign pa        = pa_q;
   assign pp        = pp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         second  <= 1'b0;
         slot    <= '0;
         vsid_q  <= '0;
         ea_q    <= '0;
         wr_q    <= 1'b0;
         base_q  <= '0;
         mask_q  <= '0;
         wdata_q <= '0;
         hit_q   <= 1'b0;
         pa_q    <= '0;
         pp_q    <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  vsid_q <= vsid;
                  ea_q   <= ea;
                  wr_q   <= is_write;
                  base_q <= tbl_base;
                  mask_q <= tbl_mask;
                  second <= 1'b0;
                  slot   <= '0;
                  hit_q  <= 1'b0;
                  st     <= S_ISSUE;
               end
            end
            S_ISSUE: st <= S_CHECK;
            S_CHECK: begin
               if (match) begin
                  hit_q   <= 1'b1;
                  pa_q    <= {w1[PA_W-1:PAGE_W], ea_q[PAGE_W-1:0]};
                  pp_q    <= w1[PP_W-1:0];
                  wdata_q <= upd_w1;
                  st      <= upd_need ? S_WBACK : S_DONE;
               end else if (slot == LAST_SLOT) begin
                  if (!second) begin
                     second <= 1'b1;
                     slot   <= '0;
                     st     <= S_ISSUE;
                  end else begin
                     hit_q <= 1'b0;
                     st    <= S_DONE;
                  end
               end else begin
                  slot <= slot + 1'b1;
                  st   <= S_ISSUE;
               end
            end
            S_WBACK: st <= S_DONE;
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hpw_walker_chk.sv
`timescale 1ns/1ps
module hpw_walker_chk #(
   parameter int EA_W    = 32,
   parameter int PA_W    = 32,
   parameter int PAGE_W  = 12,
   parameter int GROUP_N = 8,
   parameter int ENTRY_B = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [EA_W-1:0] ea,
   input logic            busy,
   input logic            done,
   input logic            hit,
   input logic [PA_W-1:0] pa,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic [PA_W-1:0] mem_addr
);
   localparam int ENT_SH = $clog2(ENTRY_B);
   localparam int CNT_W  = $clog2(2 * GROUP_N) + 2;
   localparam logic [CNT_W-1:0] MAX_RD = CNT_W'(2 * GROUP_N);

   logic [CNT_W-1:0] rd_cnt;
   logic [EA_W-1:0]  ea_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt <= '0;
         ea_l   <= '0;
      end else if (start && !busy) begin
         rd_cnt <= '0;
         ea_l   <= ea;
      end else if (mem_rd) begin
         rd_cnt <= rd_cnt + 1'b1;
      end
   end

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr && !done));
   a_r2_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr[ENT_SH-1:0] == '0));
   a_r4_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_cnt <= MAX_RD));
   a_r6_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> done);
   a_r6_write_second_word: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr[ENT_SH-1:0] == ENT_SH'(ENTRY_B / 2)));
   a_r8_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> (pa[PAGE_W-1:0] == ea_l[PAGE_W-1:0]));
   a_r9_miss_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> (rd_cnt == MAX_RD));
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   a_r10_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
endmodule

bind hpw_walker hpw_walker_chk #(
   .EA_W (EA_W), .PA_W (PA_W), .PAGE_W (PAGE_W),
   .GROUP_N (GROUP_N), .ENTRY_B (ENTRY_B)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ea       (ea),
   .busy     (busy),
   .done     (done),
   .hit      (hit),
   .pa       (pa),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr)
);

// File: tb/sim_hpw_walker.sv
`timescale 1ns/1ps
module sim_hpw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_write = 1'b0;
   logic [23:0] vsid = '0;
   logic [31:0] ea = '0;
   logic [31:0] tbl_base = '0;
   logic [31:0] tbl_mask = '0;
   logic        busy, done, hit, mem_rd, mem_wr;
   logic [31:0] pa, mem_addr, mem_wdata;
   logic [1:0]  pp;
   logic [63:0] mem_rdata = '0;

   always #10 clk = ~clk;

   hpw_walker u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .is_write (is_write),
      .vsid (vsid), .ea (ea), .tbl_base (tbl_base), .tbl_mask (tbl_mask),
      .busy (busy), .done (done), .hit (hit), .pa (pa), .pp (pp),
      .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
   );

   logic [31:0] m0 [0:4095];
   logic [31:0] m1 [0:4095];
   logic [31:0] rd_log [0:63];
   int unsigned rd_total = 0;
   int unsigned wr_total = 0;
   logic [31:0] wr_addr_l = '0;
   logic [31:0] wr_data_l = '0;

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= {m0[mem_addr[14:3]], m1[mem_addr[14:3]]};
         rd_log[rd_total[5:0]] <= mem_addr;
         rd_total <= rd_total + 1;
      end
      if (mem_wr) begin
         wr_total  <= wr_total + 1;
         wr_addr_l <= mem_addr;
         wr_data_l <= mem_wdata;
      end
   end

   int checks = 0;
   int errors = 0;
   logic [31:0] base = 32'h0010_0000;
   logic [31:0] mask = 32'h0000_7FC0;

   logic        r_hit;
   logic [31:0] r_pa, r_first, r_ninth, r_waddr, r_wdata;
   logic [1:0]  r_pp;
   int unsigned r_nrd, r_nwr;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] gaddr(input logic [23:0] v, input logic [31:0] e, input logic sec);
      logic [23:0] h;
      h = v ^ {8'h00, e[27:12]};
      if (sec) h = ~h;
      return base | (({8'h00, h} << 6) & mask);
   endfunction

   function automatic logic [31:0] mk_w0(input logic [23:0] v, input logic [31:0] e, input logic sec);
      return {1'b1, v, sec, e[27:22]};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) begin
         m0[i] = '0;
         m1[i] = '0;
      end
   endtask

   task automatic put(input logic [31:0] addr, input logic [31:0] a, input logic [31:0] b);
      m0[addr[14:3]] = a;
      m1[addr[14:3]] = b;
   endtask

   task automatic walk(input logic [23:0] v, input logic [31:0] e, input logic w, input logic poke);
      int unsigned rd0, wr0;
      int n;
      bit got;
      @(negedge clk);
      vsid = v; ea = e; is_write = w; tbl_base = base; tbl_mask = mask;
      rd0 = rd_total; wr0 = wr_total;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         start = 1'b1; vsid = ~v; ea = e ^ 32'h0F00_0FFF; is_write = ~w;
         @(negedge clk);
         start = 1'b0;
      end
      got = 1'b0;
      n = 0;
      while (!got && n < 200) begin
         if (done) got = 1'b1;
         else begin
            @(negedge clk);
            n++;
         end
      end
      chk("R10 done reached", 32'(got), 32'd1);
      r_hit   = hit;
      r_pa    = pa;
      r_pp    = pp;
      r_nrd   = rd_total - rd0;
      r_nwr   = wr_total - wr0;
      r_first = rd_log[rd0 % 64];
      r_ninth = rd_log[(rd0 + 8) % 64];
      r_waddr = wr_addr_l;
      r_wdata = wr_data_l;
      @(negedge clk);
      chk("R10 done one cycle", 32'(done), 32'd0);
      chk("R10 busy low after done", 32'(busy), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 busy in reset", 32'(busy), 32'd0);
      chk("R1 done in reset", 32'(done), 32'd0);
      chk("R1 mem_rd in reset", 32'(mem_rd), 32'd0);
      chk("R1 mem_wr in reset", 32'(mem_wr), 32'd0);
   endtask

   task automatic t_primary_hit();
      logic [23:0] v = 24'h0A53C1;
      logic [31:0] e = 32'h3456_789A;
      logic [31:0] g;
      clear_mem();
      g = gaddr(v, e, 1'b0);
      put(g + 32'd24, mk_w0(v, e, 1'b0), 32'hABCDE002);
      walk(v, e, 1'b0, 1'b0);
      chk("R2 first read address", r_first, g);
      chk("R8 hit flag", 32'(r_hit), 32'd1);
      chk("R8 physical address", r_pa, 32'hABCDE89A);
      chk("R8 pp field", 32'(r_pp), 32'd2);
      chk("R2 reads up to slot 3", r_nrd, 32'd4);
      chk("R6 one write", r_nwr, 32'd1);
      chk("R6 write address", r_waddr, g + 32'd28);
      chk("R6 referenced set", r_wdata, 32'hABCDE102);
   endtask

   task automatic t_write_flags();
      logic [23:0] v = 24'h123456;
      logic [31:0] e = 32'h7FED_C123;
      logic [31:0] g;
      clear_mem();
      g = gaddr(v, e, 1'b0);
      put(g, mk_w0(v, e, 1'b0), 32'h55555101);
      walk(v, e, 1'b1, 1'b0);
      chk("R6 changed set on write", r_wdata, 32'h55555181);
      chk("R6 write count", r_nwr, 32'd1);
      put(g, mk_w0(v, e, 1'b0), 32'h55555181);
      walk(v, e, 1'b1, 1'b0);
      chk("R7 no write when flags set", r_nwr, 32'd0);
      chk("R7 still a hit", 32'(r_hit), 32'd1);
      put(g, mk_w0(v, e, 1'b0), 32'h55555103);
      walk(v, e, 1'b0, 1'b0);
      chk("R7 read with referenced set", r_nwr, 32'd0);
      chk("R8 pp read path", 32'(r_pp), 32'd3);
   endtask

   task automatic t_secondary();
      logic [23:0] v = 24'hF0F0F0;
      logic [31:0] e = 32'h0ABC_D444;
      logic [31:0] gp, gs, good;
      clear_mem();
      gp = gaddr(v, e, 1'b0);
      gs = gaddr(v, e, 1'b1);
      good = mk_w0(v, e, 1'b0);
      put(gp,          good & 32'h7FFF_FFFF, 32'h11111000);
      put(gp + 32'd8,  good | 32'h0000_0040, 32'h22222000);
      put(gp + 32'd16, good ^ 32'h0000_0001, 32'h33333000);
      put(gp + 32'd24, good ^ 32'h0000_0080, 32'h44444000);
      put(gs + 32'd8,  good,                 32'h66666000);
      put(gs + 32'd40, mk_w0(v, e, 1'b1),    32'h77777001);
      walk(v, e, 1'b0, 1'b0);
      chk("R3 decoys skipped, hit in second group", 32'(r_hit), 32'd1);
      chk("R3 phase bit selects entry", r_pa, 32'h77777444);
      chk("R4 read count through slot 5", r_nrd, 32'd14);
      chk("R4 second group address", r_ninth, gs);
      chk("R6 write into second group", r_waddr, gs + 32'd44);
   endtask

   task automatic t_priority();
      logic [23:0] v = 24'h00BEEF;
      logic [31:0] e = 32'h5123_4F00;
      logic [31:0] g;
      clear_mem();
      g = gaddr(v, e, 1'b0);
      put(g + 32'd16, mk_w0(v, e, 1'b0), 32'hAAAAA100);
      put(g + 32'd48, mk_w0(v, e, 1'b0), 32'hBBBBB100);
      walk(v, e, 1'b0, 1'b0);
      chk("R5 lowest slot wins", r_pa, 32'hAAAAAF00);
      chk("R5 reads stop at slot 2", r_nrd, 32'd3);
   endtask

   task automatic t_miss();
      clear_mem();
      walk(24'h13579B, 32'h2468_ACE0, 1'b1, 1'b0);
      chk("R9 hit low on miss", 32'(r_hit), 32'd0);
      chk("R9 sixteen reads", r_nrd, 32'd16);
      chk("R9 no write on miss", r_nwr, 32'd0);
   endtask

   task automatic t_mask();
      logic [23:0] v = 24'hFFFFFF;
      logic [31:0] e = 32'h0000_1000;
      logic [31:0] g;
      mask = 32'h0000_1FC0;
      clear_mem();
      g = gaddr(v, e, 1'b0);
      put(g, mk_w0(v, e, 1'b0), 32'h0C0DE000);
      walk(v, e, 1'b0, 1'b0);
      chk("R2 masked group address", r_first, g);
      chk("R2 masked hit", r_pa, 32'h0C0DE000);
      mask = 32'h0000_7FC0;
   endtask

   task automatic t_busy_start();
      logic [23:0] v = 24'h0A53C1;
      logic [31:0] e = 32'h3456_789A;
      clear_mem();
      put(gaddr(v, e, 1'b0) + 32'd24, mk_w0(v, e, 1'b0), 32'hABCDE002);
      walk(v, e, 1'b0, 1'b1);
      chk("R11 start while busy ignored", r_pa, 32'hABCDE89A);
      chk("R11 read count unchanged", r_nrd, 32'd4);
      chk("R11 is_write not retaken", r_wdata, 32'hABCDE102);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_primary_hit();
      t_write_flags();
      t_secondary();
      t_priority();
      t_miss();
      t_mask();
      t_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule